// File: doc/BRIEF.md
# Parallel I/O Register Set

This block holds the three registers of a general-purpose 16-bit parallel I/O port: a control/status register, an output buffer and an input buffer. The control/status register has a sparse layout. Two command bits and two interrupt enables can be written by software. Two request lines from the device appear live in fixed positions. Every other position reads as zero.

The output buffer can be loaded by byte lane or as a full word, and it can be read back. Its contents drive the device pins at all times. The input buffer is read-only and returns the device's data word. Each load of the output buffer launches a new-data strobe toward the device. The width of that strobe, in clock cycles, is a parameter.

An address decoder in front of this block supplies one select per register and three gating strobes: read, write-low-byte and write-high-byte. The bus handshake is handled elsewhere. A bus initialise input clears the same state that reset clears.

Top module: `pio_regfile`

## Requirements
- R1: A CSR read returns cmd0 at bit 0, cmd1 at bit 1, the B enable at bit 5, the A enable at bit 6, the live request-A input at bit 7 and the live request-B input at bit 15; all other bits read 0.
- R2: With the CSR selected, a write on the low-byte strobe loads bits 0, 1, 5 and 6 from the same positions of the write data in one clock; the high-byte strobe alone changes nothing in the CSR.
- R3: The outputs `cmd[1:0]`, `ien_b` and `ien_a` always equal CSR bits 1:0, 5 and 6.
- R4: With the output buffer selected, the low-byte strobe loads bits 7:0 and the high-byte strobe loads bits 15:8; asserting both loads the whole word, and a lane whose strobe is low keeps its value.
- R5: The output buffer reads back its stored value, and `dev_out` equals that value at all times.
- R6: An input-buffer read returns `dev_in`; a write aimed at the input buffer, or at no register, changes no register.
- R7: `rdata` is 0 whenever the read strobe is low or no register is selected.
- R8: Every output-buffer load on either lane raises `new_data` for exactly PULSE_CYC cycles starting one clock after the load, and a new load restarts the count; CSR writes do not raise it.
- R9: A low `rst_n`, or a high `init`, at a clock edge clears the CSR writable bits, the output buffer and `new_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init | input | 1 | Bus initialise, synchronous clear |
| sel_csr | input | 1 | Control/status register selected |
| sel_obuf | input | 1 | Output buffer selected |
| sel_ibuf | input | 1 | Input buffer selected |
| gate_rd | input | 1 | Read strobe |
| gate_wr_lo | input | 1 | Write strobe, low byte |
| gate_wr_hi | input | 1 | Write strobe, high byte |
| wdata | input | 16 | Write data from the bus |
| rdata | output | 16 | Read data to the bus |
| dev_req_a | input | 1 | Device request A (live) |
| dev_req_b | input | 1 | Device request B (live) |
| dev_in | input | 16 | Device data word for the input buffer |
| dev_out | output | 16 | Output buffer contents to the device |
| cmd | output | 2 | Command bits to the device |
| ien_a | output | 1 | Interrupt enable A |
| ien_b | output | 1 | Interrupt enable B |
| new_data | output | 1 | New-data strobe after an output-buffer load |

## Verification
The bench writes all-ones to the CSR and checks the mask. A design that let through a reserved bit would read back more than 0x0063, and a wrong bit position would swap the two enables. A high-byte-only CSR write and writes aimed at the input buffer or at an unused select are each followed by read-backs. A design that decoded these writes would corrupt the CSR or the output buffer. Single-lane writes to the output buffer catch a lane that is loaded from the wrong strobe or cleared by the other lane. The strobe width is counted cycle by cycle for a high-lane-only load and for a retriggered load, and a CSR write must leave the strobe low. A stretcher that was off by one, or that ignored high-lane loads, would fail these counts.

// File: rtl/pio_pkg.sv
// Package: shared widths and control/status bit positions for the
// parallel I/O register set. Assumes a 16-bit bus word of two bytes.
package pio_pkg;
    localparam int WORD_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int LANES   = WORD_W / BYTE_W;

    // Control/status bit positions (software-visible layout)
    localparam int CSR_CMD0 = 0;
    localparam int CSR_CMD1 = 1;
    localparam int CSR_IENB = 5;
    localparam int CSR_IENA = 6;
    localparam int CSR_REQA = 7;
    localparam int CSR_REQB = 15;

    // Writable control state
    typedef struct packed {
        logic       ien_a;
        logic       ien_b;
        logic [1:0] cmd;
    } csr_state_t;
endpackage

// File: rtl/pio_csr.sv
// Module: pio_csr
// Holds the four writable control bits and builds the read view that
// merges them with the live device requests. Assumes the caller gives a
// write enable that is already qualified by select and low-byte strobe.
module pio_csr
    import pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    input  logic              req_a,
    input  logic              req_b,
    output csr_state_t        state,
    output logic [WORD_W-1:0] view
);
    csr_state_t state_q;

    // Load the writable bits from their own bit positions; clear on reset/init
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state_q <= '0;
        end else if (wr_en) begin
            state_q.cmd   <= {wdata[CSR_CMD1], wdata[CSR_CMD0]};
            state_q.ien_b <= wdata[CSR_IENB];
            state_q.ien_a <= wdata[CSR_IENA];
        end
    end

    // Assemble the sparse read layout; unused positions stay zero
    always_comb begin
        view           = '0;
        view[CSR_CMD0] = state_q.cmd[0];
        view[CSR_CMD1] = state_q.cmd[1];
        view[CSR_IENB] = state_q.ien_b;
        view[CSR_IENA] = state_q.ien_a;
        view[CSR_REQA] = req_a;
        view[CSR_REQB] = req_b;
    end

    assign state = state_q;
endmodule

// File: rtl/pio_obuf.sv
// Module: pio_obuf
// Output buffer with one independent load enable per byte lane. Assumes the
// lane enables are already qualified by the buffer select.
module pio_obuf
    import pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [LANES-1:0]  lane_we,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] q
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_q;

        // Load this byte lane on its own strobe; clear on reset/init
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                lane_q <= '0;
            end else if (lane_we[g]) begin
                lane_q <= wdata[g*BYTE_W +: BYTE_W];
            end
        end

        assign q[g*BYTE_W +: BYTE_W] = lane_q;
    end
endmodule

// File: rtl/pio_strobe.sv
// Module: pio_strobe
// Stretches a one-cycle trigger into an output that is high for WIDTH
// cycles, starting the cycle after the trigger. A new trigger restarts the
// count. Assumes WIDTH >= 1.
module pio_strobe #(
    parameter int WIDTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic trig,
    output logic pulse
);
    localparam int CW = $clog2(WIDTH + 1);

    logic [CW-1:0] remain_q;

    // Reload on trigger, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            remain_q <= '0;
        end else if (trig) begin
            remain_q <= CW'(WIDTH);
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign pulse = (remain_q != '0);
endmodule

// File: rtl/pio_regfile.sv
// Module: pio_regfile (top)
// Register set of a 16-bit parallel I/O port: control/status, output buffer
// and input buffer, plus a new-data strobe on output buffer loads. Assumes
// that at most one select is active at a time and that the decoder supplies
// the gating strobes. The bus handshake is handled outside this block.
module pio_regfile
    import pio_pkg::*;
#(
    parameter int PULSE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              sel_csr,
    input  logic              sel_obuf,
    input  logic              sel_ibuf,
    input  logic              gate_rd,
    input  logic              gate_wr_lo,
    input  logic              gate_wr_hi,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic              dev_req_a,
    input  logic              dev_req_b,
    input  logic [WORD_W-1:0] dev_in,
    output logic [WORD_W-1:0] dev_out,
    output logic [1:0]        cmd,
    output logic              ien_a,
    output logic              ien_b,
    output logic              new_data
);
    csr_state_t        csr_st;
    logic [WORD_W-1:0] csr_view;
    logic [WORD_W-1:0] obuf_q;
    logic [LANES-1:0]  obuf_we;
    logic              csr_we;

    // Only the low-byte strobe reaches the control/status register
    assign csr_we  = sel_csr & gate_wr_lo;
    assign obuf_we = {sel_obuf & gate_wr_hi, sel_obuf & gate_wr_lo};

    pio_csr u_csr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (init),
        .wr_en (csr_we),
        .wdata (wdata),
        .req_a (dev_req_a),
        .req_b (dev_req_b),
        .state (csr_st),
        .view  (csr_view)
    );

    pio_obuf u_obuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (init),
        .lane_we (obuf_we),
        .wdata   (wdata),
        .q       (obuf_q)
    );

    pio_strobe #(.WIDTH(PULSE_CYC)) u_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (init),
        .trig  (|obuf_we),
        .pulse (new_data)
    );

    // Read multiplexer: zero unless a register is selected under the read strobe
    always_comb begin
        rdata = '0;
        if (gate_rd) begin
            if (sel_csr)       rdata = csr_view;
            else if (sel_obuf) rdata = obuf_q;
            else if (sel_ibuf) rdata = dev_in;
        end
    end

    assign dev_out = obuf_q;
    assign cmd     = csr_st.cmd;
    assign ien_a   = csr_st.ien_a;
    assign ien_b   = csr_st.ien_b;
endmodule

// File: rtl/pio_regfile_chk.sv
// Module: pio_regfile_chk
// Checker bound to pio_regfile. Relates the strobes to the register state
// over time. Assumes a synchronous active-low reset.
module pio_regfile_chk #(
    parameter int PULSE_CYC = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        init,
    input logic        sel_csr,
    input logic        sel_obuf,
    input logic        sel_ibuf,
    input logic        gate_rd,
    input logic        gate_wr_lo,
    input logic        gate_wr_hi,
    input logic [15:0] wdata,
    input logic [15:0] rdata,
    input logic        dev_req_a,
    input logic        dev_req_b,
    input logic [15:0] dev_in,
    input logic [15:0] dev_out,
    input logic [1:0]  cmd,
    input logic        ien_a,
    input logic        ien_b,
    input logic        new_data
);
    // CSR read shows the live requests and the held control state
    p_csr_layout_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_csr && gate_rd) |-> (rdata[7] == dev_req_a && rdata[15] == dev_req_b
            && rdata[6] == ien_a && rdata[5] == ien_b && rdata[1:0] == cmd));

    // High-byte strobe alone leaves the CSR state untouched
    p_csr_hi_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_csr && gate_wr_hi && !gate_wr_lo && !init) |=> $stable({ien_a, ien_b, cmd}));

    // Low-lane load puts the write data on the device pins
    p_obuf_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_obuf && gate_wr_lo && !init) |=> (dev_out[7:0] == $past(wdata[7:0])));

    // High-lane load puts the write data on the device pins
    p_obuf_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_obuf && gate_wr_hi && !init) |=> (dev_out[15:8] == $past(wdata[15:8])));

    // Without a buffer load or init the pins hold
    p_obuf_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(sel_obuf && (gate_wr_lo || gate_wr_hi)) && !init) |=> $stable(dev_out));

    // A read with the strobe low gives zero
    p_rdata_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_rd |-> (rdata == 16'h0000));

    // Any buffer load raises the strobe on the next cycle
    p_strobe_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_obuf && (gate_wr_lo || gate_wr_hi) && !init) |=> new_data);

    // Init clears all held state
    p_init_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (dev_out == 16'h0000 && cmd == 2'b00 && !ien_a && !ien_b && !new_data));

    logic unused_ok;
    assign unused_ok = &{1'b0, sel_ibuf, dev_in, PULSE_CYC[0]};
endmodule

bind pio_regfile pio_regfile_chk #(.PULSE_CYC(PULSE_CYC)) chk_i (.*);

// File: tb/pio_regfile_tb_top.sv
// Bench for pio_regfile: a vector table of register accesses, then directed
// tests for reset, init and the new-data strobe.
module pio_regfile_tb_top;
    localparam int PULSE_CYC = 4;
    localparam int NV = 19;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init = 1'b0;
    logic        sel_csr = 1'b0, sel_obuf = 1'b0, sel_ibuf = 1'b0;
    logic        gate_rd = 1'b0, gate_wr_lo = 1'b0, gate_wr_hi = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        dev_req_a = 1'b0, dev_req_b = 1'b0;
    logic [15:0] dev_in = '0;
    logic [15:0] dev_out;
    logic [1:0]  cmd;
    logic        ien_a, ien_b, new_data;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pio_regfile #(.PULSE_CYC(PULSE_CYC)) dut_i (.*);

    // Vector: reg[55:54] (0 csr,1 obuf,2 ibuf,3 none), ctl[53:51] {rd,hi,lo},
    // wdata[50:35], dev_in[34:19], req_a[18], req_b[17], check[16], expect[15:0]
    localparam logic [55:0] VEC [NV] = '{
        {2'd1, 3'b011, 16'hA5C3, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000}, // R4 word
        {2'd1, 3'b100, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 16'hA5C3}, // R5
        {2'd1, 3'b001, 16'h1234, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000}, // R4 lo
        {2'd1, 3'b100, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 16'hA534},
        {2'd1, 3'b010, 16'hBEEF, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000}, // R4 hi
        {2'd1, 3'b100, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 16'hBE34},
        {2'd0, 3'b001, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000}, // R2 mask
        {2'd0, 3'b100, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h0063}, // R1
        {2'd0, 3'b100, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b1, 16'h80E3}, // R1 live
        {2'd0, 3'b010, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000}, // R2 hi only
        {2'd0, 3'b100, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b1, 16'h8063},
        {2'd0, 3'b001, 16'h0041, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000},
        {2'd0, 3'b100, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b1, 16'h00C1},
        {2'd2, 3'b100, 16'h0000, 16'h5A0F, 1'b0, 1'b0, 1'b1, 16'h5A0F}, // R6
        {2'd2, 3'b011, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000}, // R6 ignored
        {2'd3, 3'b011, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000}, // R6 ignored
        {2'd1, 3'b100, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 16'hBE34},
        {2'd0, 3'b100, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h0041},
        {2'd3, 3'b100, 16'h0000, 16'h7777, 1'b1, 1'b1, 1'b1, 16'h0000}  // R7
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        {sel_csr, sel_obuf, sel_ibuf, gate_rd, gate_wr_lo, gate_wr_hi} = '0;
        wdata = '0;
    endtask

    // Apply one vector at a falling edge; check reads before the rising edge
    task automatic apply(input logic [55:0] v);
        @(negedge clk);
        sel_csr    = (v[55:54] == 2'd0);
        sel_obuf   = (v[55:54] == 2'd1);
        sel_ibuf   = (v[55:54] == 2'd2);
        {gate_rd, gate_wr_hi, gate_wr_lo} = v[53:51];
        wdata      = v[50:35];
        dev_in     = v[34:19];
        dev_req_a  = v[18];
        dev_req_b  = v[17];
        #2;
        if (v[16]) check("R1/R5/R6/R7 read", rdata, v[15:0]);
    endtask

    task automatic obuf_write(input logic hi, input logic lo, input logic [15:0] d);
        @(negedge clk);
        sel_obuf = 1'b1; gate_wr_hi = hi; gate_wr_lo = lo; wdata = d;
        @(negedge clk);
        idle();
    endtask

    // Count strobe-high cycles at falling edges until it drops
    task automatic count_pulse(output int n);
        n = 0;
        for (int i = 0; i < 20; i++) begin
            if (new_data) n++;
            else break;
            @(negedge clk);
        end
    endtask

    initial begin
        int w;
        // Reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset dev_out", dev_out, 16'h0000);
        check("R9 reset csr", {11'b0, ien_a, ien_b, new_data, cmd}, 16'h0000);
        check("R7 idle rdata", rdata, 16'h0000);

        for (int i = 0; i < NV; i++) apply(VEC[i]);
        @(negedge clk);
        idle();
        #2;
        check("R5 dev_out pins", dev_out, 16'hBE34);
        check("R3 cmd/ien outputs", {12'b0, ien_a, ien_b, cmd}, 16'h0009);

        // Strobe width after a high-lane-only load
        repeat (8) @(negedge clk);
        obuf_write(1'b1, 1'b0, 16'h5500);
        count_pulse(w);
        check("R8 strobe width hi lane", 16'(w), 16'(PULSE_CYC));

        // Retrigger partway through restarts the count
        obuf_write(1'b0, 1'b1, 16'h0011);
        @(negedge clk);
        sel_obuf = 1'b1; gate_wr_lo = 1'b1; wdata = 16'h0022;
        @(negedge clk);
        idle();
        count_pulse(w);
        check("R8 strobe retrigger", 16'(w), 16'(PULSE_CYC));
        check("R4 lo lane after retrigger", dev_out, 16'h5522);

        // CSR write must not raise the strobe
        repeat (6) @(negedge clk);
        @(negedge clk);
        sel_csr = 1'b1; gate_wr_lo = 1'b1; wdata = 16'h0022;
        @(negedge clk);
        idle();
        check("R8 no strobe on CSR write", {15'b0, new_data}, 16'h0000);
        check("R3 ien_b set", {12'b0, ien_a, ien_b, cmd}, 16'h0006);

        // Init clears the held state
        obuf_write(1'b1, 1'b1, 16'hFFFF);
        init = 1'b1;
        @(negedge clk);
        init = 1'b0;
        check("R9 init dev_out", dev_out, 16'h0000);
        check("R9 init csr/strobe", {11'b0, ien_a, ien_b, new_data, cmd}, 16'h0000);

        // Synchronous reset mid-run
        obuf_write(1'b1, 1'b1, 16'h1357);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R9 reset mid-run", dev_out, 16'h0000);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule